// File: doc/BRIEF.md
# Zero-Sample Auto-Mute Detector

This block watches a two-channel stream of audio samples and decides, per channel, when the input has been silent long enough to mute that channel. Each channel has its own counter of consecutive all-zero samples. A sample counts as silent only if every bit of it is zero. When the counter reaches the threshold chosen by that channel's 3-bit time code, the channel is qualified and its auto-mute status rises. A single nonzero sample resets the counter and releases the mute.

The eight thresholds are a fixed table of sample counts: 1104, 5088, 10224, 25584, 51360, 102240, 255840 and 511680 for codes 0 to 7. At a 96 kHz sample rate these are roughly 11.5 ms up to 5.33 s, and the real time scales with the actual rate. The parameter `THR_SHIFT` (0 to 4) divides every table entry by a power of two, so that a short test build or a slow rate reuses the same logic. Each channel has an enable. A joint mode holds both channels unmuted until both have qualified on their own. A combined flag reports that both channels are muted. The volume ramp that follows a mute lies outside this block.

Top module: `zsm_automute`

## Requirements
- R1: A time code c (0 to 7, ascending) selects a threshold of T(c) >> THR_SHIFT samples, where T = {1104, 5088, 10224, 25584, 51360, 102240, 255840, 511680}.
- R2: With a channel enabled, its status reads 1 just after the clock edge that accepts the threshold-th consecutive valid all-zero sample, and reads 0 one sample earlier.
- R3: A valid sample with any bit set (including only the MSB) clears that channel's count, so its status reads 0 after that edge. The other channel is unaffected.
- R4: Cycles with `smp_valid` low neither advance a count nor break a run of zeros.
- R5: While a channel's enable is 0, its status is 0 in the same cycle and its count is cleared at each edge. After it is re-enabled, a full new run of zeros is needed.
- R6: With `joint` = 1, both statuses are 1 only while both channels are qualified, and both are 0 otherwise. With `joint` = 0 the channels act independently.
- R7: `mute_both` is 1 exactly when `mute_a` and `mute_b` are both 1.
- R8: A count stops at its threshold rather than growing or wrapping. Raising the threshold afterwards therefore requires (new − old) more zero samples.
- R9: After reset, all counts are 0 and all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A sample pair is present this cycle |
| smp_a | input | SAMPLE_W | Channel 1 sample |
| smp_b | input | SAMPLE_W | Channel 2 sample |
| en_a | input | 1 | Auto-mute enable, channel 1 |
| en_b | input | 1 | Auto-mute enable, channel 2 |
| joint | input | 1 | 1: mute both channels only when both qualify |
| tcode_a | input | 3 | Time code, channel 1 |
| tcode_b | input | 3 | Time code, channel 2 |
| mute_a | output | 1 | Channel 1 auto-muted |
| mute_b | output | 1 | Channel 2 auto-muted |
| mute_both | output | 1 | Both channels auto-muted |

## Verification
The bench walks every time code to its exact threshold and checks one sample short of it. A table entry that is off by one, or a status that is registered one stage late, shows up as a flag at the wrong sample. Idle gaps inside a run catch a design that counts invalid cycles or restarts on them. A nonzero sample carrying only the MSB catches a zero test that looks only at the low bits. The saturation case raises the threshold after an overlong run: a design whose counter kept climbing or wrapped would mute too early or never. Joint-mode and enable cases catch a design that lets one channel mute alone or keeps stale counts after being disabled.

// File: rtl/zsm_pkg.sv
package zsm_pkg;
   // Silence thresholds in samples at full scale, indexed by time code.
   function automatic int unsigned zsm_base_count(input logic [2:0] code);
      int unsigned n;
      case (code)
         3'd0:    n = 1104;
         3'd1:    n = 5088;
         3'd2:    n = 10224;
         3'd3:    n = 25584;
         3'd4:    n = 51360;
         3'd5:    n = 102240;
         3'd6:    n = 255840;
         default: n = 511680;
      endcase
      return n;
   endfunction

   localparam int unsigned ZSM_MAX_COUNT = 511680;
   localparam int unsigned ZSM_MAX_SHIFT = 4;
endpackage

// File: rtl/zsm_thresh_lut.sv
module zsm_thresh_lut #(
   parameter int CNT_W     = 19,
   parameter int THR_SHIFT = 0
) (
   input  logic [2:0]       code,
   output logic [CNT_W-1:0] thr
);
   import zsm_pkg::*;
   // R1: scaled table lookup
   always_comb begin
      thr = CNT_W'(zsm_base_count(code) >> THR_SHIFT);
   end
endmodule

// File: rtl/zsm_zero_counter.sv
module zsm_zero_counter #(
   parameter int SAMPLE_W = 24,
   parameter int CNT_W    = 19
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                valid,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [CNT_W-1:0]    thr,
   output logic [CNT_W-1:0]    cnt,
   output logic                qual
);
   logic is_zero;

   assign is_zero = (sample == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en) begin
         cnt <= '0;                      // R5
      end else if (valid) begin          // R4: idle cycles hold
         if (!is_zero)
            cnt <= '0;                   // R3
         else if (cnt < thr)
            cnt <= cnt + 1'b1;           // R8: stops at threshold
      end
   end

   assign qual = en && (cnt >= thr);     // R2
endmodule

// File: rtl/zsm_mute_combine.sv
module zsm_mute_combine #(
   parameter int NCH = 2
) (
   input  logic           joint,
   input  logic [NCH-1:0] qual,
   output logic [NCH-1:0] mute,
   output logic           mute_all
);
   logic all_qual;

   assign all_qual = &qual;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      // R6: joint mode waits for every channel
      assign mute[ch] = joint ? all_qual : qual[ch];
   end

   assign mute_all = &mute;              // R7
endmodule

// File: rtl/zsm_automute.sv
module zsm_automute #(
   parameter int SAMPLE_W  = 24,
   parameter int THR_SHIFT = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_a,
   input  logic [SAMPLE_W-1:0] smp_b,
   input  logic                en_a,
   input  logic                en_b,
   input  logic                joint,
   input  logic [2:0]          tcode_a,
   input  logic [2:0]          tcode_b,
   output logic                mute_a,
   output logic                mute_b,
   output logic                mute_both
);
   import zsm_pkg::*;

   localparam int NCH     = 2;
   localparam int MAX_THR = int'(ZSM_MAX_COUNT >> THR_SHIFT);
   localparam int CNT_W   = $clog2(MAX_THR + 1);

   if (SAMPLE_W < 1) begin : g_bad_w
      $error("zsm_automute: SAMPLE_W must be at least 1");
   end
   if (THR_SHIFT < 0 || THR_SHIFT > int'(ZSM_MAX_SHIFT)) begin : g_bad_s
      $error("zsm_automute: THR_SHIFT must be within 0..4");
   end

   logic [SAMPLE_W-1:0] smp_arr [NCH];
   logic [2:0]          code_arr[NCH];
   logic [NCH-1:0]      en_arr;
   logic [CNT_W-1:0]    thr_w   [NCH];
   logic [CNT_W-1:0]    cnt_q   [NCH];
   logic [NCH-1:0]      qual;
   logic [NCH-1:0]      mute_w;

   assign smp_arr[0]  = smp_a;
   assign smp_arr[1]  = smp_b;
   assign code_arr[0] = tcode_a;
   assign code_arr[1] = tcode_b;
   assign en_arr      = {en_b, en_a};

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      zsm_thresh_lut #(
         .CNT_W    (CNT_W),
         .THR_SHIFT(THR_SHIFT)
      ) u_lut (
         .code(code_arr[ch]),
         .thr (thr_w[ch])
      );

      zsm_zero_counter #(
         .SAMPLE_W(SAMPLE_W),
         .CNT_W   (CNT_W)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (en_arr[ch]),
         .valid (smp_valid),
         .sample(smp_arr[ch]),
         .thr   (thr_w[ch]),
         .cnt   (cnt_q[ch]),
         .qual  (qual[ch])
      );
   end

   zsm_mute_combine #(.NCH(NCH)) u_comb (
      .joint   (joint),
      .qual    (qual),
      .mute    (mute_w),
      .mute_all(mute_both)
   );

   assign mute_a = mute_w[0];
   assign mute_b = mute_w[1];
endmodule

// File: rtl/zsm_automute_chk.sv
module zsm_automute_chk #(
   parameter int SAMPLE_W = 24,
   parameter int CNT_W    = 19
) (
   input logic                clk,
   input logic                rst_n,
   input logic                smp_valid,
   input logic [SAMPLE_W-1:0] smp_a,
   input logic [SAMPLE_W-1:0] smp_b,
   input logic                en_a,
   input logic                en_b,
   input logic                joint,
   input logic                mute_a,
   input logic                mute_b,
   input logic                mute_both,
   input logic [CNT_W-1:0]    cnt_a,
   input logic [CNT_W-1:0]    cnt_b,
   input logic [CNT_W-1:0]    thr_a,
   input logic [CNT_W-1:0]    thr_b
);
   a_r2_mute_needs_run_a: assert property (@(posedge clk) disable iff (!rst_n)
      mute_a |-> (cnt_a >= thr_a));
   a_r2_mute_needs_run_b: assert property (@(posedge clk) disable iff (!rst_n)
      mute_b |-> (cnt_b >= thr_b));

   a_r3_nonzero_clears_a: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && en_a && smp_a != '0) |=> !mute_a);
   a_r3_nonzero_clears_b: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && en_b && smp_b != '0) |=> !mute_b);

   a_r4_idle_holds_a: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a && !smp_valid) |=> (cnt_a == $past(cnt_a)));
   a_r4_idle_holds_b: assert property (@(posedge clk) disable iff (!rst_n)
      (en_b && !smp_valid) |=> (cnt_b == $past(cnt_b)));

   a_r5_disabled_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
      !en_a |-> !mute_a);
   a_r5_disabled_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
      !en_b |-> !mute_b);

   a_r6_joint_same: assert property (@(posedge clk) disable iff (!rst_n)
      joint |-> (mute_a == mute_b));

   a_r7_both_flag: assert property (@(posedge clk) disable iff (!rst_n)
      mute_both == (mute_a && mute_b));

   a_r8_saturate_a: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a && smp_valid && smp_a == '0 && cnt_a >= thr_a) |=> (cnt_a == $past(cnt_a)));
   a_r8_saturate_b: assert property (@(posedge clk) disable iff (!rst_n)
      (en_b && smp_valid && smp_b == '0 && cnt_b >= thr_b) |=> (cnt_b == $past(cnt_b)));
endmodule

bind zsm_automute zsm_automute_chk #(
   .SAMPLE_W(SAMPLE_W),
   .CNT_W   (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_valid(smp_valid),
   .smp_a    (smp_a),
   .smp_b    (smp_b),
   .en_a     (en_a),
   .en_b     (en_b),
   .joint    (joint),
   .mute_a   (mute_a),
   .mute_b   (mute_b),
   .mute_both(mute_both),
   .cnt_a    (cnt_q[0]),
   .cnt_b    (cnt_q[1]),
   .thr_a    (thr_w[0]),
   .thr_b    (thr_w[1])
);

// File: tb/zsm_automute_test.sv
`timescale 1ns/1ps
module zsm_automute_test;
   localparam int SW    = 24;
   localparam int SHIFT = 4;
   // R1: expected thresholds = full-scale counts divided by 16
   localparam int unsigned EXP_THR [8] = '{69, 318, 639, 1599, 3210, 6390, 15990, 31980};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [SW-1:0] smp_a = '0;
   logic [SW-1:0] smp_b = '0;
   logic          en_a = 1'b0;
   logic          en_b = 1'b0;
   logic          joint = 1'b0;
   logic [2:0]    tcode_a = 3'd5;
   logic [2:0]    tcode_b = 3'd5;
   logic          mute_a, mute_b, mute_both;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   zsm_automute #(.SAMPLE_W(SW), .THR_SHIFT(SHIFT)) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_a(smp_a), .smp_b(smp_b), .en_a(en_a), .en_b(en_b),
      .joint(joint), .tcode_a(tcode_a), .tcode_b(tcode_b),
      .mute_a(mute_a), .mute_b(mute_b), .mute_both(mute_both)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic outs(input string tag, input int ea, input int eb, input int eboth);
      #1;
      check({tag, " mute_a"}, int'(mute_a), ea);
      check({tag, " mute_b"}, int'(mute_b), eb);
      check({tag, " mute_both"}, int'(mute_both), eboth);
   endtask

   // n valid samples of (a,b); valid drops afterwards
   task automatic push(input logic [SW-1:0] a, input logic [SW-1:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_valid = 1'b1; smp_a = a; smp_b = b;
      end
      @(negedge clk);
      smp_valid = 1'b0; smp_a = '0; smp_b = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(4ns * 190000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      idle(3);
      outs("R9 in reset", 0, 0, 0);
      @(negedge clk); rst_n = 1'b1;
      en_a = 1'b1; en_b = 1'b1;
      outs("R9 after reset", 0, 0, 0);

      // R1/R2: walk every time code to its exact threshold on both channels
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         tcode_a = 3'(c); tcode_b = 3'(c);
         push(24'h1, 24'h1, 1);
         push('0, '0, EXP_THR[c] - 1);
         outs($sformatf("R1 code %0d one short", c), 0, 0, 0);
         push('0, '0, 1);
         outs($sformatf("R2 code %0d at threshold", c), 1, 1, 1);
         push(24'h1, 24'h1, 1);
      end

      @(negedge clk); tcode_a = 3'd0; tcode_b = 3'd0;

      // R4: idle gaps do not count and do not break a run
      push('0, '0, 30);
      idle(20);
      push('0, '0, 38);
      outs("R4 gap one short", 0, 0, 0);
      push('0, '0, 1);
      outs("R4 gap at threshold", 1, 1, 1);

      // R3: MSB-only nonzero on A restarts A, B keeps its run
      push(24'h1, 24'h1, 1);
      push('0, '0, 50);
      push(24'h800000, '0, 1);
      push('0, '0, 68);
      outs("R3 A restarted", 0, 1, 0);
      push('0, '0, 1);
      outs("R3 A re-qualified", 1, 1, 1);
      push(24'h000100, '0, 1);
      outs("R3 A released", 0, 1, 0);

      // R5: disabling clears status at once and the count at the edge
      push('0, '0, 69);
      outs("R5 setup", 1, 1, 1);
      @(negedge clk); en_a = 1'b0;
      outs("R5 disabled immediate", 0, 1, 0);
      push('0, '0, 100);
      outs("R5 disabled ignores zeros", 0, 1, 0);
      @(negedge clk); en_a = 1'b1;
      outs("R5 re-enabled cleared", 0, 1, 0);
      push('0, '0, 68);
      outs("R5 fresh run one short", 0, 1, 0);
      push('0, '0, 1);
      outs("R5 fresh run done", 1, 1, 1);

      // R8: saturation, then a raised threshold needs the difference
      push(24'h1, 24'h1, 1);
      push('0, '0, 200);
      outs("R8 saturated", 1, 1, 1);
      @(negedge clk); tcode_a = 3'd1;
      outs("R8 threshold raised", 0, 1, 0);
      push('0, '0, 248);
      outs("R8 one short of 318", 0, 1, 0);
      push('0, '0, 1);
      outs("R8 reaches 318", 1, 1, 1);

      // R6: joint mode, A short (69) and B long (318)
      @(negedge clk); joint = 1'b1; tcode_a = 3'd0; tcode_b = 3'd1;
      push(24'h1, 24'h1, 1);
      push('0, '0, 100);
      outs("R6 joint A only qualified", 0, 0, 0);
      push('0, '0, 217);
      outs("R6 joint B one short", 0, 0, 0);
      push('0, '0, 1);
      outs("R6 joint both qualified", 1, 1, 1);
      push('0, 24'h4, 1);
      outs("R6 joint B breaks both", 0, 0, 0);

      // R7: independent mode, one muted channel does not raise the combined flag
      @(negedge clk); joint = 1'b0;
      outs("R7 independent A alone", 1, 0, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule